// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Controller

This block gives software control over a bank of general-purpose pins behind a small 32-bit register bus. Each pin can be an input or an output. Two write-only strobes drive output latch bits high or low without a read-modify-write. Incoming pin levels are resynchronised into the clock domain, and the synchronised level can be read back.

Each pin has its own rising-edge enable and falling-edge enable. Either one, both or neither may be set. An enabled transition of the synchronised level sets a sticky status bit, and software clears that bit by writing a one to it. The low-numbered pins each raise a dedicated interrupt line that mirrors their status bit. All remaining pins share one combined line. An alternate-function word is stored and read back for the pin multiplexer outside this block.

The pin count, the number of dedicated interrupt lines and the synchroniser depth are parameters. The defaults are 28 pins, 11 dedicated lines and 2 synchroniser stages. The register index is taken from address bits [4:2], so the register at index k sits at byte offset 4k.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and no interrupt line is active.
- R2: Reading index 0 (offset 0x00) returns `pin_in` through two flip-flop stages. A change is not visible after one rising clock edge and is visible after the second.
- R3: Index 1 (offset 0x04) holds the direction. A bit set to 1 makes that pin an output, so the matching `pin_oe` bit is 1. The register reads back as written, and `pin_oe` changes only on a write to this index.
- R4: Writing index 2 (offset 0x08) sets every output latch bit written as 1 and leaves bits written as 0 unchanged. `pin_out` shows the latch, and index 2 reads back the latch.
- R5: Writing index 3 (offset 0x0C) clears every output latch bit written as 1 and leaves the rest unchanged. Index 3 reads as zero.
- R6: When a pin's bit in the rising enable (index 4, offset 0x10) is 1, a low-to-high change of its synchronised level sets its status bit. The status bit is readable at index 6 (offset 0x18) on the third clock edge after `pin_in` changes.
- R7: When a pin's bit in the falling enable (index 5, offset 0x14) is 1, a high-to-low change sets its status bit. With both enables set, both directions set the bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Writing all ones clears every pending bit.
- R9: If an enabled edge and a clearing write to the same status bit occur in the same cycle, the bit stays set.
- R10: For each pin n below the dedicated-line count (11), `irq_line[n]` equals status bit n. `irq_shared` is the OR of status bits 11 to 27.
- R11: A pin whose rising and falling enables are both 0 sets no status bit on any transition.
- R12: Index 7 (offset 0x1C) stores the alternate-function word and reads it back. Bits 31 to 28 of every register read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 28 | Pad input levels, asynchronous |
| pin_out | output | 28 | Output latch value to the pads |
| pin_oe | output | 28 | Pad output enable, 1 = drive |
| irq_line | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
The checker watches several properties on every cycle. No status bit may fall without a clearing write, and every detected edge must land in the status register even when a clear arrives in the same cycle. No new bit may appear while all enables are off. `pin_oe` may not move without a direction write, a set write must raise the bits it names, and the unused upper read bits must stay zero.

Some behaviour only the bench can show, by sweeping every pin through all four enable combinations in both directions. This covers which status bit and which interrupt line respond, the exact cycle in which the synchronised level and the status bit appear, and the effect of the set and clear strobes on the latch.

// File: rtl/pio_pkg.sv
package pio_pkg;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned ADDR_W = 5;

   typedef enum logic [2:0] {
      REG_LEVEL = 3'd0,
      REG_DIR   = 3'd1,
      REG_SET   = 3'd2,
      REG_CLR   = 3'd3,
      REG_RISE  = 3'd4,
      REG_FALL  = 3'd5,
      REG_STAT  = 3'd6,
      REG_ALT   = 3'd7
   } pio_reg_e;

endpackage

// File: rtl/pio_sync.sv
// Multi-stage resynchroniser for asynchronous pad inputs.
module pio_sync #(
   parameter int unsigned W      = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff_q <= '0;
            end else begin
               ff_q[0] <= d_i;
               for (int s = 1; s < int'(STAGES); s++) begin
                  ff_q[s] <= ff_q[s-1];
               end
            end
         end
         assign q_o = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pio_edge_status.sv
// Per-pin edge detector feeding a sticky, write-one-to-clear status register.
module pio_edge_status #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_i,
   input  logic [W-1:0] rise_en_i,
   input  logic [W-1:0] fall_en_i,
   input  logic         clr_stb_i,
   input  logic [W-1:0] clr_mask_i,
   output logic [W-1:0] event_o,
   output logic [W-1:0] status_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] status_q;
   logic [W-1:0] clr_eff;

   generate
      for (genvar i = 0; i < int'(W); i++) begin : g_bit
         assign event_o[i] = (rise_en_i[i] &  sync_i[i] & ~prev_q[i]) |
                             (fall_en_i[i] & ~sync_i[i] &  prev_q[i]);
      end
   endgenerate

   assign clr_eff = clr_stb_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         status_q <= '0;
      end else begin
         prev_q   <= sync_i;
         // a fresh edge takes priority over a simultaneous clear
         status_q <= (status_q & ~clr_eff) | event_o;
      end
   end

   assign status_o = status_q;

endmodule

// File: rtl/pio_regs.sv
// Register file: direction, output latch with set/clear strobes, edge enables, alternate word.
module pio_regs
   import pio_pkg::*;
#(
   parameter int unsigned W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  pio_reg_e         idx_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [W-1:0]     level_i,
   input  logic [W-1:0]     status_i,
   output logic [BUS_W-1:0] rdata_o,
   output logic [W-1:0]     dir_o,
   output logic [W-1:0]     out_o,
   output logic [W-1:0]     rise_o,
   output logic [W-1:0]     fall_o,
   output logic [W-1:0]     alt_o,
   output logic             clr_stb_o,
   output logic [W-1:0]     clr_mask_o
);

   logic [W-1:0] wd;
   logic         wdata_unused;
   logic [W-1:0] dir_q, out_q, rise_q, fall_q, alt_q;
   logic [W-1:0] rd_val;

   assign wd           = wdata_i[W-1:0];
   assign wdata_unused = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         alt_q  <= '0;
      end else if (wr_i) begin
         case (idx_i)
            REG_DIR:  dir_q  <= wd;
            REG_SET:  out_q  <= out_q | wd;
            REG_CLR:  out_q  <= out_q & ~wd;
            REG_RISE: rise_q <= wd;
            REG_FALL: fall_q <= wd;
            REG_ALT:  alt_q  <= wd;
            default:  ;
         endcase
      end
   end

   assign clr_stb_o  = wr_i && (idx_i == REG_STAT);
   assign clr_mask_o = wd;

   always_comb begin
      case (idx_i)
         REG_LEVEL: rd_val = level_i;
         REG_DIR:   rd_val = dir_q;
         REG_SET:   rd_val = out_q;
         REG_CLR:   rd_val = '0;
         REG_RISE:  rd_val = rise_q;
         REG_FALL:  rd_val = fall_q;
         REG_STAT:  rd_val = status_i;
         REG_ALT:   rd_val = alt_q;
         default:   rd_val = '0;
      endcase
      rdata_o          = '0;
      rdata_o[W-1:0]   = rd_val;
   end

   assign dir_o  = dir_q;
   assign out_o  = out_q;
   assign rise_o = rise_q;
   assign fall_o = fall_q;
   assign alt_o  = alt_q;

endmodule

// File: rtl/pio_irq_map.sv
// Splits status into dedicated lines for low pins and one OR-combined line for the rest.
module pio_irq_map #(
   parameter int unsigned W      = 28,
   parameter int unsigned DIRECT = 11
) (
   input  logic [W-1:0]      status_i,
   output logic [DIRECT-1:0] irq_line_o,
   output logic              irq_shared_o
);

   generate
      for (genvar i = 0; i < int'(DIRECT); i++) begin : g_direct
         assign irq_line_o[i] = status_i[i];
      end
      if (DIRECT < W) begin : g_shared
         assign irq_shared_o = |status_i[W-1:DIRECT];
      end else begin : g_no_shared
         assign irq_shared_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pio_edge_ctrl.sv
// Top level of the edge-detecting GPIO controller.
module pio_edge_ctrl
   import pio_pkg::*;
#(
   parameter int unsigned NUM_PINS       = 28,
   parameter int unsigned NUM_DIRECT_IRQ = 11,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [BUS_W-1:0]          bus_wdata,
   output logic [BUS_W-1:0]          bus_rdata,
   input  logic [NUM_PINS-1:0]       pin_in,
   output logic [NUM_PINS-1:0]       pin_out,
   output logic [NUM_PINS-1:0]       pin_oe,
   output logic [NUM_DIRECT_IRQ-1:0] irq_line,
   output logic                      irq_shared
);

   localparam int unsigned W = NUM_PINS;

   generate
      if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
         $error("NUM_PINS must lie between 1 and the bus width");
      end
      if (NUM_DIRECT_IRQ < 1 || NUM_DIRECT_IRQ > NUM_PINS) begin : g_bad_irq
         $error("NUM_DIRECT_IRQ must lie between 1 and NUM_PINS");
      end
   endgenerate

   pio_reg_e     reg_idx;
   logic         addr_lo_unused;
   logic [W-1:0] sync_lvl;
   logic [W-1:0] edge_ev;
   logic [W-1:0] stat_q;
   logic [W-1:0] dir_q, out_q, rise_en_q, fall_en_q, alt_q;
   logic         clr_stb;
   logic [W-1:0] clr_mask;

   assign reg_idx        = pio_reg_e'(bus_addr[4:2]);
   assign addr_lo_unused = ^bus_addr[1:0];

   pio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (sync_lvl)
   );

   pio_regs #(.W(W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .idx_i      (reg_idx),
      .wdata_i    (bus_wdata),
      .level_i    (sync_lvl),
      .status_i   (stat_q),
      .rdata_o    (bus_rdata),
      .dir_o      (dir_q),
      .out_o      (out_q),
      .rise_o     (rise_en_q),
      .fall_o     (fall_en_q),
      .alt_o      (alt_q),
      .clr_stb_o  (clr_stb),
      .clr_mask_o (clr_mask)
   );

   pio_edge_status #(.W(W)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (sync_lvl),
      .rise_en_i  (rise_en_q),
      .fall_en_i  (fall_en_q),
      .clr_stb_i  (clr_stb),
      .clr_mask_i (clr_mask),
      .event_o    (edge_ev),
      .status_o   (stat_q)
   );

   pio_irq_map #(.W(W), .DIRECT(NUM_DIRECT_IRQ)) u_irq (
      .status_i     (stat_q),
      .irq_line_o   (irq_line),
      .irq_shared_o (irq_shared)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/pio_edge_ctrl_chk.sv
// Cycle-by-cycle properties of the controller, attached by bind.
module pio_edge_ctrl_chk
   import pio_pkg::*;
#(
   parameter int unsigned NUM_PINS       = 28,
   parameter int unsigned NUM_DIRECT_IRQ = 11
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [BUS_W-1:0]          bus_wdata,
   input logic [BUS_W-1:0]          bus_rdata,
   input logic [NUM_PINS-1:0]       pin_out,
   input logic [NUM_PINS-1:0]       pin_oe,
   input logic [NUM_DIRECT_IRQ-1:0] irq_line,
   input logic                      irq_shared,
   input logic [NUM_PINS-1:0]       stat_q,
   input logic [NUM_PINS-1:0]       edge_ev,
   input logic [NUM_PINS-1:0]       rise_en_q,
   input logic [NUM_PINS-1:0]       fall_en_q
);

   logic stat_wr, dir_wr, set_wr;
   assign stat_wr = bus_wr && (bus_addr[4:2] == REG_STAT);
   assign dir_wr  = bus_wr && (bus_addr[4:2] == REG_DIR);
   assign set_wr  = bus_wr && (bus_addr[4:2] == REG_SET);

   // R8: a status bit only falls after a clearing write
   p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R9: every detected edge lands, even against a clear
   p_event_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_ev != '0) |=> ((stat_q & $past(edge_ev)) == $past(edge_ev)));

   // R11: no new status bits while every enable is off
   p_quiet_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_en_q | fall_en_q) == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

   // R3: output enables move only on a direction write
   p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr |=> $stable(pin_oe));

   // R4: a set write raises every bit it names
   p_set_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

   // R10: the dedicated lines follow the low status bits
   p_direct_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_line == stat_q[NUM_DIRECT_IRQ-1:0]);

   generate
      if (NUM_PINS < BUS_W) begin : g_upper
         // R12: upper read bits stay zero
         p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[BUS_W-1:NUM_PINS] == '0);
      end
   endgenerate

   logic shared_unused;
   assign shared_unused = irq_shared;

endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(
   .NUM_PINS       (NUM_PINS),
   .NUM_DIRECT_IRQ (NUM_DIRECT_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq_line   (irq_line),
   .irq_shared (irq_shared),
   .stat_q     (stat_q),
   .edge_ev    (edge_ev),
   .rise_en_q  (rise_en_q),
   .fall_en_q  (fall_en_q)
);

// File: tb/tb_pio_edge_ctrl.sv
module tb_pio_edge_ctrl;

   localparam int NP = 28;
   localparam int ND = 11;
   localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C,
                          A_RISE = 5'h10, A_FALL = 5'h14, A_STAT = 5'h18, A_ALT = 5'h1C;
   localparam logic [31:0] ALL = 32'h0FFF_FFFF;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_wr;
   logic [4:0]    bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic [ND-1:0] irq_line;
   logic          irq_shared;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pio_edge_ctrl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pin_in     (pin_in),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe),
      .irq_line   (irq_line),
      .irq_shared (irq_shared)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // called at a negedge, returns at the following negedge
   task automatic wr(logic [4:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic cyc(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   function automatic logic [31:0] irq_exp(logic [31:0] st);
      return {20'b0, |st[NP-1:ND], st[ND-1:0]};
   endfunction

   function automatic logic [31:0] irq_act();
      return {20'b0, irq_shared, irq_line};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] exp;
      logic [31:0] regs[8];
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int k = 0; k < 8; k++) begin
         rd(5'(k * 4), v);
         chk("R1", v, 32'h0);
      end
      chk("R1", {4'b0, pin_oe}, 32'h0);
      chk("R1", {4'b0, pin_out}, 32'h0);
      chk("R1", irq_act(), 32'h0);

      // R2: two-stage synchroniser latency
      pin_in = 28'h5A3_C96F;
      rd(A_LVL, v); chk("R2", v, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(A_LVL, v); chk("R2", v, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(A_LVL, v); chk("R2", v, 32'h05A3_C96F);
      pin_in = 28'h0;
      cyc(3);
      rd(A_LVL, v); chk("R2", v, 32'h0);
      rd(A_STAT, v); chk("R11", v, 32'h0);

      // R3: direction
      wr(A_DIR, 32'hFFFF_FFFF);
      rd(A_DIR, v); chk("R3", v, ALL);
      chk("R3", {4'b0, pin_oe}, ALL);
      wr(A_DIR, 32'h0A5A_5A53);
      chk("R3", {4'b0, pin_oe}, 32'h0A5A_5A53);
      wr(A_ALT, 32'h1);
      chk("R3", {4'b0, pin_oe}, 32'h0A5A_5A53);

      // R4 / R5: set and clear strobes
      exp = 32'h0;
      for (int k = 0; k < NP; k += 3) begin
         wr(A_SET, 32'h1 << k);
         exp |= 32'h1 << k;
         chk("R4", {4'b0, pin_out}, exp);
      end
      wr(A_SET, 32'h00F0_00F0);
      exp |= 32'h00F0_00F0;
      rd(A_SET, v); chk("R4", v, exp);
      wr(A_SET, 32'h0);
      chk("R4", {4'b0, pin_out}, exp);
      wr(A_CLR, 32'h0000_0030);
      exp &= ~32'h0000_0030;
      chk("R5", {4'b0, pin_out}, exp);
      wr(A_CLR, 32'h0);
      chk("R5", {4'b0, pin_out}, exp);
      rd(A_CLR, v); chk("R5", v, 32'h0);
      wr(A_CLR, 32'hFFFF_FFFF);
      chk("R5", {4'b0, pin_out}, 32'h0);

      // R12: alternate word and upper bits
      wr(A_ALT, 32'hFFFF_FFFF);
      rd(A_ALT, v); chk("R12", v, ALL);
      wr(A_ALT, 32'h3123_4567);
      rd(A_ALT, v); chk("R12", v, 32'h0123_4567);
      wr(A_RISE, 32'hF000_0000);
      rd(A_RISE, v); chk("R12", v, 32'h0);

      // R6 / R7 / R10 / R11: sweep every pin through every enable mode
      for (int m = 0; m < 4; m++) begin
         wr(A_RISE, ((m & 1) != 0) ? 32'hFFFF_FFFF : 32'h0);
         wr(A_FALL, ((m & 2) != 0) ? 32'hFFFF_FFFF : 32'h0);
         for (int p = 0; p < NP; p++) begin
            pin_in[p] = 1'b1;
            cyc(3);
            exp = ((m & 1) != 0) ? (32'h1 << p) : 32'h0;
            rd(A_STAT, v); chk((m == 0) ? "R11" : "R6", v, exp);
            chk("R10", irq_act(), irq_exp(exp));
            wr(A_STAT, 32'hFFFF_FFFF);
            rd(A_STAT, v); chk("R8", v, 32'h0);
            pin_in[p] = 1'b0;
            cyc(3);
            exp = ((m & 2) != 0) ? (32'h1 << p) : 32'h0;
            rd(A_STAT, v); chk((m == 0) ? "R11" : "R7", v, exp);
            chk("R10", irq_act(), irq_exp(exp));
            wr(A_STAT, 32'hFFFF_FFFF);
         end
      end

      // R8: zero writes leave status untouched, ones clear selectively
      pin_in[3] = 1'b1; pin_in[20] = 1'b1;
      cyc(3);
      exp = (32'h1 << 3) | (32'h1 << 20);
      rd(A_STAT, v); chk("R8", v, exp);
      wr(A_STAT, 32'h0);
      rd(A_STAT, v); chk("R8", v, exp);
      wr(A_STAT, 32'h1 << 3);
      rd(A_STAT, v); chk("R8", v, 32'h1 << 20);
      chk("R10", irq_act(), irq_exp(32'h1 << 20));
      pin_in = '0;
      cyc(3);
      wr(A_STAT, 32'hFFFF_FFFF);

      // R9: edge and clear in the same cycle
      pin_in[5] = 1'b1; pin_in[6] = 1'b1;
      cyc(3);
      rd(A_STAT, v); chk("R9", v, (32'h1 << 5) | (32'h1 << 6));
      pin_in[5] = 1'b0;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      wr(A_STAT, (32'h1 << 5) | (32'h1 << 6));
      rd(A_STAT, v); chk("R9", v, 32'h1 << 5);
      chk("R10", irq_act(), irq_exp(32'h1 << 5));

      // register snapshot for R12 upper bits
      for (int k = 0; k < 8; k++) begin
         rd(5'(k * 4), regs[k]);
         chk("R12", {regs[k][31:28], 28'h0}, 32'h0);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule